// File: doc/BRIEF.md
# Eight-Channel Common-Start Interval Digitizer

This block measures eight time intervals that begin at one shared start event. Each channel has a synchronous counter that advances once per resolution tick (one clock cycle stands for one 100 ps unit). The counter runs from the accepted start until that channel's own stop pulse or the shared common-stop pulse arrives. If no stop comes within the full-scale window of 2047 ticks, an internal timeout ends the channel and marks it as overrange.

A start is taken only while the unit is idle, not vetoed and not inhibited. After a start is taken the unit stays busy, and further starts are rejected, until a clear returns it to idle. A self-test start arms all channels with their stop inputs masked, so every channel overruns. A one-cycle done strobe reports that all eight channels have finished. All inputs are single-cycle pulses that are already synchronised to `clk`.

Top module: `tdc8_top`

## Requirements
- R1: When the unit is idle, a start pulse that is neither vetoed nor inhibited is accepted at that clock edge. `busy_o` is high from the next cycle, and every channel count restarts from 0.
- R2: A start pulse is ignored, and `busy_o` stays low, when `veto_i` is high in the same cycle or when `inhibit_i` is high. `inhibit_i` also blocks a self-test start.
- R3: While `busy_o` is high, start and self-test pulses have no effect. Running counts are not restarted, and finished results are not changed.
- R4: A channel's stop sampled k clock edges after the accepting edge, with 1 <= k <= 2047, gives a result of count = k in bits [10:0] of that channel's 12-bit slot, with the overrun bit (bit 11) at 0. Channel i occupies `result_o[12*i +: 12]`.
- R5: Only the first stop (own stop or common stop) after a start is used. Later stops on that channel leave its result unchanged.
- R6: A channel with no stop by edge 2047 times out at edge 2048. Its result becomes 0xFFF: overrun bit 1, count saturated at 2047. A stop sampled at edge 2048 or later is treated as a timeout.
- R7: `common_stop_i` ends every channel that is still running in the same cycle, so those channels all hold the same count.
- R8: A self-test start (`test_start_i`) arms all channels with individual and common stops masked. Every result ends as 0xFFF.
- R9: `done_o` is high for exactly one cycle per measurement, one cycle after the edge at which the last channel finished.
- R10: `clear_i` returns the unit to idle on the next edge from any state. It zeroes all results, cancels a measurement in progress so that no done strobe follows, and allows a new start.
- R11: After reset, `busy_o` and `done_o` are low and all results are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Resolution tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Shared start pulse |
| veto_i | input | 1 | Suppresses a start pulse in the same cycle |
| inhibit_i | input | 1 | Blocks all starts while high |
| test_start_i | input | 1 | Self-test start with all stops masked |
| stop_i | input | NCH (8) | Per-channel stop pulses |
| common_stop_i | input | 1 | Stops all channels at once |
| clear_i | input | 1 | Returns the unit to idle and zeroes the results |
| busy_o | output | 1 | A measurement is in progress or being held |
| done_o | output | 1 | One-cycle strobe when all channels have finished |
| result_o | output | NCH*(CW+1) (96) | Per-channel {overrun, count} |

## Verification
A start or clear takes effect at the edge that samples it, so `busy_o` and the results are read at the falling edge that follows. A stop sampled at edge k after the accepting edge shows up as count k right after that edge. A timeout completes at edge 2048. The done strobe comes one edge after the last channel finishes. The bench drives every pulse at a falling edge and numbers the rising edges from the accepting edge, so each expected count and the done edge are computed from those numbers. It records the edge at which each done pulse appears and compares that edge with the predicted one, rather than only checking that the strobe occurred.

// File: rtl/tdc8_pkg.sv
package tdc8_pkg;

    // Measurement phase of the shared controller
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // waiting for a start
        PH_RUN  = 2'd1,  // at least one channel still counting
        PH_HELD = 2'd2   // all channels finished, results held until clear
    } phase_e;

endpackage

// File: rtl/tdc8_chan.sv
module tdc8_chan #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          arm_i,
    input  logic          stop_en_i,
    input  logic          stop_i,
    output logic [CW-1:0] count_o,
    output logic          ovr_o,
    output logic          run_o
);

    localparam logic [CW-1:0] FULL = '1;

    typedef struct packed {
        logic [CW-1:0] count;
        logic          ovr;
        logic          run;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (arm_i) begin
            st_d.count = '0;
            st_d.ovr   = 1'b0;
            st_d.run   = 1'b1;
        end else if (st_q.run) begin
            if (st_q.count == FULL) begin
                // full-scale window used up: internal timeout
                st_d.ovr = 1'b1;
                st_d.run = 1'b0;
            end else begin
                st_d.count = st_q.count + 1'b1;
                if (stop_en_i && stop_i) begin
                    st_d.run = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign ovr_o   = st_q.ovr;
    assign run_o   = st_q.run;

    // overrange results carry a saturated count
    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovr |-> (st_q.count == FULL));

    // a channel that reaches full scale times out on the next edge
    assert_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.count == FULL && !clear_i && !arm_i) |=> st_q.ovr);

    // a finished channel ignores later stops
    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !arm_i && !clear_i) |=> $stable(st_q.count));

endmodule

// File: rtl/tdc8_ctrl.sv
module tdc8_ctrl
    import tdc8_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           veto_i,
    input  logic           inhibit_i,
    input  logic           test_start_i,
    input  logic           clear_i,
    input  logic [NCH-1:0] run_i,
    output logic           arm_o,
    output logic           stop_en_o,
    output logic           busy_o,
    output logic           done_o
);

    typedef struct packed {
        phase_e phase;
        logic   test;
        logic   done;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  take_ext;
    logic  arm;

    always_comb begin
        take_ext = start_i && !veto_i;
        arm      = (st_q.phase == PH_IDLE) && !clear_i && !inhibit_i
                   && (take_ext || test_start_i);

        st_d      = st_q;
        st_d.done = 1'b0;
        if (clear_i) begin
            st_d = '0;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    if (arm) begin
                        st_d.phase = PH_RUN;
                        st_d.test  = test_start_i;
                    end
                end
                PH_RUN: begin
                    if (run_i == '0) begin
                        st_d.phase = PH_HELD;
                        st_d.done  = 1'b1;
                    end
                end
                PH_HELD: ;
                default: st_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign arm_o     = arm;
    assign stop_en_o = !st_q.test;
    assign busy_o    = (st_q.phase != PH_IDLE);
    assign done_o    = st_q.done;

    assert_veto_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && start_i && veto_i && !test_start_i)
        |=> (st_q.phase == PH_IDLE));

    assert_inhibit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && inhibit_i) |=> (st_q.phase == PH_IDLE));

    assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE && !clear_i) |=> (st_q.phase != PH_IDLE));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.phase == PH_IDLE && !st_q.done));

endmodule

// File: rtl/tdc8_top.sv
module tdc8_top #(
    parameter int NCH = 8,
    parameter int CW  = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                veto_i,
    input  logic                inhibit_i,
    input  logic                test_start_i,
    input  logic [NCH-1:0]      stop_i,
    input  logic                common_stop_i,
    input  logic                clear_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [NCH*(CW+1)-1:0] result_o
);

    localparam int SW = CW + 1;

    logic           arm;
    logic           stop_en;
    logic [NCH-1:0] run;

    tdc8_ctrl #(.NCH(NCH)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .veto_i       (veto_i),
        .inhibit_i    (inhibit_i),
        .test_start_i (test_start_i),
        .clear_i      (clear_i),
        .run_i        (run),
        .arm_o        (arm),
        .stop_en_o    (stop_en),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [CW-1:0] count;
        logic          ovr;

        tdc8_chan #(.CW(CW)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear_i   (clear_i),
            .arm_i     (arm),
            .stop_en_i (stop_en),
            .stop_i    (stop_i[g] | common_stop_i),
            .count_o   (count),
            .ovr_o     (ovr),
            .run_o     (run[g])
        );

        assign result_o[g*SW +: SW] = {ovr, count};
    end

    // all channels start together
    assert_common_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !clear_i) |=> (run == '1));

endmodule

// File: tb/test_tdc8_top.sv
module test_tdc8_top;

    localparam int  NCH        = 8;
    localparam int  CW         = 11;
    localparam int  SW         = CW + 1;
    localparam int  FS         = 2047;
    localparam time CLK_PERIOD = 10ns;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_i = 1'b0;
    logic                veto_i = 1'b0;
    logic                inhibit_i = 1'b0;
    logic                test_start_i = 1'b0;
    logic [NCH-1:0]      stop_i = '0;
    logic                common_stop_i = 1'b0;
    logic                clear_i = 1'b0;
    logic                busy_o;
    logic                done_o;
    logic [NCH*SW-1:0]   result_o;

    int n_checks = 0;
    int n_fail   = 0;

    int t1 [NCH];
    int t2 [NCH];
    int tc;

    tdc8_top #(.NCH(NCH), .CW(CW)) i_tdc8_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .veto_i        (veto_i),
        .inhibit_i     (inhibit_i),
        .test_start_i  (test_start_i),
        .stop_i        (stop_i),
        .common_stop_i (common_stop_i),
        .clear_i       (clear_i),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .result_o      (result_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] res(input int ch);
        return result_o[ch*SW +: SW];
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_unit();
        clear_i = 1'b1;
        tick(1);
        clear_i = 1'b0;
        check("R10", "busy after clear", busy_o, 0);
        check("R10", "results after clear", result_o == '0, 1);
    endtask

    // accept a start at the next edge; returns at the falling edge after it
    task automatic do_start(input bit self_test);
        if (self_test) test_start_i = 1'b1; else start_i = 1'b1;
        tick(1);
        start_i = 1'b0;
        test_start_i = 1'b0;
        check(self_test ? "R8" : "R1", "busy after start", busy_o, 1);
    endtask

    // drives stops per the t1/t2/tc tables; edge c counted from the accepting edge
    task automatic run_measure(input string req, input bit self_test, input int restart_at);
        int fin [NCH];
        int last = 0;
        int done_cnt = 0;
        int done_edge = -1;
        int busy_bad = 0;
        for (int i = 0; i < NCH; i++) begin
            int eff = 0;
            if (t1[i] > 0) eff = t1[i];
            if (t2[i] > 0 && (eff == 0 || t2[i] < eff)) eff = t2[i];
            if (tc > 0 && (eff == 0 || tc < eff)) eff = tc;
            if (self_test) eff = 0;
            fin[i] = (eff >= 1 && eff <= FS) ? eff : FS + 1;
            if (fin[i] > last) last = fin[i];
        end
        do_start(self_test);
        for (int c = 1; c <= last + 3; c++) begin
            for (int i = 0; i < NCH; i++) stop_i[i] = (t1[i] == c) || (t2[i] == c);
            common_stop_i = (tc == c);
            start_i = (c == restart_at);
            test_start_i = (c == restart_at + 1);
            tick(1);
            stop_i = '0;
            common_stop_i = 1'b0;
            start_i = 1'b0;
            test_start_i = 1'b0;
            if (done_o) begin done_cnt++; done_edge = c; end
            if (!busy_o) busy_bad++;
        end
        for (int i = 0; i < NCH; i++) begin
            logic [SW-1:0] exp;
            exp = (fin[i] <= FS) ? SW'(fin[i]) : {SW{1'b1}};
            check(req, $sformatf("result ch%0d", i), res(i), exp);
        end
        check("R9", "done pulse count", done_cnt, 1);
        check("R9", "done edge", done_edge, last + 1);
        check("R3", "busy held during measurement", busy_bad, 0);
    endtask

    task automatic clear_tables();
        for (int i = 0; i < NCH; i++) begin t1[i] = 0; t2[i] = 0; end
        tc = 0;
    endtask

    task automatic test_reset();
        check("R11", "busy after reset", busy_o, 0);
        check("R11", "done after reset", done_o, 0);
        check("R11", "results after reset", result_o == '0, 1);
    endtask

    // R4, R6, R3: distinct stops, a late stop, a timeout and a restart attempt
    task automatic test_individual();
        clear_unit();
        clear_tables();
        t1 = '{5, 17, 1, 100, FS, FS + 1, 0, 640};
        run_measure("R4", 1'b0, 50);
        check("R6", "overrun ch6", res(6), 12'hFFF);
        check("R6", "late stop ch5 is timeout", res(5), 12'hFFF);
    endtask

    task automatic test_first_stop();
        clear_unit();
        clear_tables();
        t1 = '{10, 3, 200, 1, 7, 8, 9, 11};
        t2 = '{20, 4, 300, 2, 1500, 2047, 2048, 12};
        run_measure("R5", 1'b0, 0);
    endtask

    task automatic test_common();
        clear_unit();
        clear_tables();
        t1[2] = 12;
        t1[5] = 40;
        tc = 33;
        run_measure("R7", 1'b0, 0);
        check("R7", "same count ch0 ch7", res(0) == res(7), 1);
    endtask

    task automatic test_block_start();
        clear_unit();
        start_i = 1'b1; veto_i = 1'b1;
        tick(1);
        start_i = 1'b0; veto_i = 1'b0;
        check("R2", "vetoed start", busy_o, 0);
        start_i = 1'b1; inhibit_i = 1'b1;
        tick(1);
        start_i = 1'b0;
        check("R2", "inhibited start", busy_o, 0);
        test_start_i = 1'b1;
        tick(1);
        test_start_i = 1'b0; inhibit_i = 1'b0;
        check("R2", "inhibited self-test", busy_o, 0);
        tick(3);
        check("R2", "no results after blocked starts", result_o == '0, 1);
    endtask

    task automatic test_selftest();
        clear_unit();
        clear_tables();
        for (int i = 0; i < NCH; i++) t1[i] = 5 + i;
        tc = 9;
        run_measure("R8", 1'b1, 0);
    endtask

    task automatic test_clear_midrun();
        int dn = 0;
        clear_unit();
        do_start(1'b0);
        tick(20);
        clear_unit();
        for (int c = 0; c < 2100; c++) begin
            tick(1);
            if (done_o || busy_o) dn++;
        end
        check("R10", "no done or busy after cancel", dn, 0);
        clear_tables();
        t1 = '{6, 6, 6, 6, 6, 6, 6, 2};
        run_measure("R10", 1'b0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        tick(2);
        rst_n = 1'b1;
        tick(1);
        test_reset();
        test_individual();
        test_first_stop();
        test_common();
        test_block_start();
        test_selftest();
        test_clear_midrun();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule